// File: doc/BRIEF.md
# Second-Order Digital Sigma-Delta Modulator

This block converts a stream of signed multi-bit samples, one per oversampling clock, into a one-bit pulse-density stream. The density of ones follows the input level. Two delaying accumulators sit in cascade, and each one subtracts a feedback level of plus or minus full scale. A single comparator reads the sign of the last active accumulator. The `order2_i` input selects the loop order at run time. With `order2_i` low, only the first accumulator is in the loop and the noise is shaped by (1-z^-1). With `order2_i` high, both accumulators are in the loop and the shaping becomes (1-z^-1)^2.

Two guards keep the loop bounded. Each accumulator saturates at a symmetric limit. A run-length monitor watches the output bit. When the output has repeated the same value for a set number of clocks, the monitor treats the loop as overloaded and zeroes both accumulators on the following enabled clock.

The registered output bit is also provided as a small two's-complement word holding +1 or -1, which can drive a one-bit DAC path directly.

Top module: `sdm2_mod`

## Requirements
- R1: While `rst_ni` is low, both accumulators are zero, `bit_o` is 0 and `code_o` is all ones.
- R2: On each enabled clock, the quantizer decision is 1 when the selected accumulator is greater than or equal to zero, and 0 otherwise. That decision is registered onto `bit_o`. A decision of 1 feeds back +REF and a decision of 0 feeds back -REF, where REF = 2^(IN_W-1)-1 (32767 by default).
- R3: Both accumulators update from the state held before the clock. The first adds the input and subtracts the feedback. The second adds the old first-accumulator value and subtracts the same feedback.
- R4: With `order2_i` = 0, the decision uses the first accumulator and the second accumulator is held at zero. With `order2_i` = 1, the decision uses the second accumulator. After reset, a full-scale input of +REF in second order gives 0 on the second clock.
- R5: In first order after reset, a zero input gives `bit_o` = 1, 0, 1, 0, and so on, starting on the first enabled clock.
- R6: In first order after reset, an input equal to +REF gives `bit_o` = 1 on every clock.
- R7: With input 6553 (0.2 of REF), the fraction of ones over 2000 clocks is within 0.6±0.01 in first order and 0.6±0.015 in second order. This corresponds to a ±1 average of about 0.2.
- R8: Each accumulator saturates at ±SAT_LIM (2^22 by default) and never leaves that range.
- R9: A run counter tracks how many consecutive clocks `bit_o` has held its value. On the enabled clock after the counter reaches RUN_LIM (default 32), both accumulators load zero and the count restarts at one. In second order with input +REF after reset, `bit_o` is 0 on clocks 2 and 37 and 1 on clocks 1 and 3 to 36.
- R10: While `en_i` is low, the accumulators, the run counter, `bit_o` and `code_o` hold their values.
- R11: `code_o` is 0...01 (+1) when `bit_o` is 1 and 1...11 (-1) when `bit_o` is 0, CODE_W bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; the loop advances only when high |
| order2_i | input | 1 | 1 selects the second-order loop, 0 the first-order loop |
| sample_i | input | IN_W | Signed input sample |
| bit_o | output | 1 | Registered pulse-density output bit |
| code_o | output | CODE_W | Output bit as a two's-complement +1 / -1 word |

## Verification
Some properties are checked by assertions on every cycle. These cover the accumulator bounds, the clear of both accumulators after a run trip, the run counter never exceeding its limit and restarting at one, the second accumulator being held at zero in first order, and the output staying frozen while the enable is low. Other behaviour needs a scenario and can only be shown by the bench. This includes the alternating pattern for a zero input, the all-ones stream at full scale, the bit density that tracks a 0.2 input, the exact clock on which overload recovery shows up as a zero in the stream, and the change in recovery time after an accumulator has sat at its clamp. The bench checks these by comparing the stream bit by bit against a model built from the requirements.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Feedback level: positive full scale of an in_w-bit signed input
  function automatic int ref_level(input int in_w);
    return (1 << (in_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/sdm_integ.sv
module sdm_integ #(
  parameter int ACC_W   = 24,
  parameter int SAT_LIM = 1 << 22
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic signed [ACC_W-1:0] add_i,
  input  logic signed [ACC_W-1:0] fb_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'(SAT_LIM);
  localparam logic signed [SUM_W-1:0] LO = -HI;
  localparam logic signed [ACC_W-1:0] LIM_A = ACC_W'(SAT_LIM);

  logic signed [SUM_W-1:0] sum;
  logic signed [ACC_W-1:0] nxt;
  logic signed [ACC_W-1:0] acc_q;

  always_comb begin
    sum = SUM_W'(acc_q) + SUM_W'(add_i) - SUM_W'(fb_i);
    if (sum > HI)      nxt = HI[ACC_W-1:0];
    else if (sum < LO) nxt = LO[ACC_W-1:0];
    else               nxt = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (en_i)  acc_q <= clr_i ? '0 : nxt;
  end

  assign acc_o = acc_q;

  assert_acc_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q <= LIM_A) && (acc_q >= -LIM_A));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> (acc_q == '0));

endmodule

// File: rtl/sdm_quant.sv
module sdm_quant #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input  logic                    order2_i,
  input  logic signed [ACC_W-1:0] acc_lo_i,
  input  logic signed [ACC_W-1:0] acc_hi_i,
  output logic                    q_o,
  output logic signed [ACC_W-1:0] fb_o
);
  localparam int REF = sdm_pkg::ref_level(IN_W);
  localparam logic signed [ACC_W-1:0] FB_P = ACC_W'(REF);
  localparam logic signed [ACC_W-1:0] FB_N = -FB_P;

  logic signed [ACC_W-1:0] last;

  always_comb begin
    last = order2_i ? acc_hi_i : acc_lo_i;
    q_o  = ~last[ACC_W-1];
    fb_o = q_o ? FB_P : FB_N;
  end

endmodule

// File: rtl/sdm_run_guard.sv
module sdm_run_guard #(
  parameter int RUN_LIM = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_new_i,
  input  logic bit_cur_i,
  output logic trip_o
);
  localparam int CNT_W = $clog2(RUN_LIM + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(RUN_LIM);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign trip_o = (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (trip_o)                                      cnt_q <= ONE;
      else if ((cnt_q != '0) && (bit_new_i == bit_cur_i)) cnt_q <= cnt_q + ONE;
      else                                             cnt_q <= ONE;
    end
  end

  assert_run_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);

  assert_trip_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && trip_o) |=> (cnt_q == ONE));

endmodule

// File: rtl/sdm2_mod.sv
module sdm2_mod #(
  parameter int IN_W    = 16,
  parameter int ACC_W   = 24,
  parameter int SAT_LIM = 1 << 22,
  parameter int RUN_LIM = 32,
  parameter int CODE_W  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   order2_i,
  input  logic signed [IN_W-1:0] sample_i,
  output logic                   bit_o,
  output logic [CODE_W-1:0]      code_o
);
  localparam int NSTG = 2;

  logic signed [ACC_W-1:0] acc      [NSTG];
  logic signed [ACC_W-1:0] stage_in [NSTG];
  logic [NSTG-1:0]         stg_clr;
  logic signed [ACC_W-1:0] fb;
  logic                    q;
  logic                    trip;
  logic                    bit_q;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stage_in[k] = ACC_W'(sample_i);
      assign stg_clr[k]  = trip;
    end else begin : g_tail
      // later stages leave the loop in first-order mode
      assign stage_in[k] = acc[k-1];
      assign stg_clr[k]  = trip | ~order2_i;
    end

    sdm_integ #(
      .ACC_W   (ACC_W),
      .SAT_LIM (SAT_LIM)
    ) u_integ (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .clr_i  (stg_clr[k]),
      .add_i  (stage_in[k]),
      .fb_i   (fb),
      .acc_o  (acc[k])
    );
  end

  sdm_quant #(
    .IN_W  (IN_W),
    .ACC_W (ACC_W)
  ) u_quant (
    .order2_i (order2_i),
    .acc_lo_i (acc[0]),
    .acc_hi_i (acc[1]),
    .q_o      (q),
    .fb_o     (fb)
  );

  sdm_run_guard #(
    .RUN_LIM (RUN_LIM)
  ) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .bit_new_i (q),
    .bit_cur_i (bit_q),
    .trip_o    (trip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bit_q <= 1'b0;
    else if (en_i) bit_q <= q;
  end

  assign bit_o  = bit_q;
  assign code_o = {{(CODE_W-1){~bit_q}}, 1'b1};

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(bit_o) && $stable(acc[0]) && $stable(acc[1])));

  assert_first_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !order2_i) |=> (acc[1] == '0));

endmodule

// File: tb/sdm2_mod_tb_top.sv
`timescale 1ns/1ps
module sdm2_mod_tb_top;
  localparam longint REF = 32767;
  localparam int NV = 7;
  // {order2, sample, cycles}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'd0,          16'd40},
    {1'b1, 16'd0,          16'd40},
    {1'b0, 16'(-16384),    16'd60},
    {1'b1, 16'd12000,      16'd80},
    {1'b1, 16'(-32767),    16'd80},
    {1'b0, 16'd32767,      16'd40},
    {1'b1, 16'(-20000),    16'd60}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_ni, en, ord2;
  logic signed [15:0] smp;
  logic               b_main, b_sat;
  logic [3:0]         c_main, c_sat;

  sdm2_mod dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .order2_i(ord2),
    .sample_i(smp), .bit_o(b_main), .code_o(c_main)
  );

  sdm2_mod #(.SAT_LIM(1 << 17), .RUN_LIM(1000)) dut_sat_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .order2_i(ord2),
    .sample_i(smp), .bit_o(b_sat), .code_o(c_sat)
  );

  int checks = 0;
  int fails  = 0;

  longint m_i1 [2];
  longint m_i2 [2];
  longint m_lim[2];
  int     m_cnt[2];
  int     m_rl [2];
  bit     m_b  [2];

  function automatic longint clampv(input longint v, input longint lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 2; k++) begin
      m_i1[k] = 0; m_i2[k] = 0; m_b[k] = 1'b0; m_cnt[k] = 0;
    end
  endtask

  task automatic model_step(input bit o2, input longint x);
    for (int k = 0; k < 2; k++) begin
      longint last, fb, n1, n2;
      bit q, trip;
      last = o2 ? m_i2[k] : m_i1[k];
      q    = (last >= 0);
      fb   = q ? REF : -REF;
      trip = (m_cnt[k] == m_rl[k]);
      n1 = clampv(m_i1[k] + x - fb, m_lim[k]);
      n2 = clampv(m_i2[k] + m_i1[k] - fb, m_lim[k]);
      if (trip) begin n1 = 0; n2 = 0; end
      if (!o2) n2 = 0;
      if (trip)                             m_cnt[k] = 1;
      else if (m_cnt[k] != 0 && q == m_b[k]) m_cnt[k] = m_cnt[k] + 1;
      else                                   m_cnt[k] = 1;
      m_i1[k] = n1; m_i2[k] = n2; m_b[k] = q;
    end
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check(b_main == m_b[0], "R2 R3 stream bit", b_main, m_b[0]);
    check(c_main == (m_b[0] ? 4'h1 : 4'hF), "R11 code word", c_main, m_b[0] ? 4'h1 : 4'hF);
    check(b_sat == m_b[1], "R8 clamped stream bit", b_sat, m_b[1]);
    check(c_sat == (m_b[1] ? 4'h1 : 4'hF), "R11 code word clamp", c_sat, m_b[1] ? 4'h1 : 4'hF);
  endtask

  task automatic cyc();
    @(posedge clk); #2;
    if (en && rst_ni) model_step(ord2, longint'(smp));
    cmp_all();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; en = 1'b1;
    model_clear();
    @(posedge clk); #2;
    check(b_main == 1'b0, "R1 reset bit", b_main, 0);
    check(c_main == 4'hF, "R1 reset code", c_main, 4'hF);
    @(posedge clk); #2;
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int ones;
    int diffs;
    bit hb;
    logic [3:0] hc;
    m_lim[0] = 64'd1 << 22; m_rl[0] = 32;
    m_lim[1] = 64'd1 << 17; m_rl[1] = 1000;
    ord2 = 1'b0; smp = '0; en = 1'b1; rst_ni = 1'b0;

    // R5: zero input alternates in first order
    do_reset();
    ord2 = 1'b0; smp = 16'sd0;
    for (int n = 1; n <= 8; n++) begin
      cyc();
      check(b_main == (n % 2 == 1), "R5 zero-input alternation", b_main, n % 2);
    end

    // R6: full scale gives all ones
    do_reset();
    smp = 16'sd32767;
    for (int n = 1; n <= 100; n++) begin
      cyc();
      check(b_main == 1'b1, "R6 full-scale ones", b_main, 1);
    end

    // R9 / R4: second order full scale, overload recovery
    do_reset();
    ord2 = 1'b1; smp = 16'sd32767;
    for (int n = 1; n <= 37; n++) begin
      bit e;
      cyc();
      e = !(n == 2 || n == 37);
      if (n == 2) check(b_main == e, "R4 second-order early zero", b_main, e);
      else        check(b_main == e, "R9 run-guard recovery", b_main, e);
    end

    // vector table, model compared every clock
    do_reset();
    for (int v = 0; v < NV; v++) begin
      ord2 = VEC[v][32];
      smp  = VEC[v][31:16];
      for (int n = 0; n < int'(VEC[v][15:0]); n++) cyc();
    end

    // R10: enable low freezes everything
    en = 1'b0; hb = b_main; hc = c_main;
    for (int n = 0; n < 10; n++) begin
      cyc();
      check(b_main == hb && c_main == hc, "R10 hold while disabled", b_main, hb);
    end
    en = 1'b1;
    for (int n = 0; n < 20; n++) cyc();

    // R7: density tracks 0.2 input
    do_reset();
    ord2 = 1'b0; smp = 16'sd6553; ones = 0;
    for (int n = 0; n < 2000; n++) begin cyc(); ones += int'(b_main); end
    check(ones >= 1180 && ones <= 1220, "R7 first-order density", ones, 1200);
    do_reset();
    ord2 = 1'b1; smp = 16'sd6553; ones = 0;
    for (int n = 0; n < 2000; n++) begin cyc(); ones += int'(b_main); end
    check(ones >= 1170 && ones <= 1230, "R7 second-order density", ones, 1200);

    // R8: clamp shortens recovery after overdrive
    do_reset();
    ord2 = 1'b1; smp = 16'sd32767;
    for (int n = 0; n < 20; n++) cyc();
    smp = -16'sd32767; diffs = 0;
    for (int n = 0; n < 60; n++) begin cyc(); diffs += int'(b_main != b_sat); end
    check(diffs > 0, "R8 clamp changes recovery", diffs, 1);

    finish_run();
  end
endmodule